// File: doc/BRIEF.md
# Six-Channel High/Low Pulse Generator

This block is a bank of independent pulse generators that sit behind a plain word-wide register port. Software sets each channel's waveform as two cycle counts: how long the pin stays high and how long it then stays low. It also sets a low "lead-in" delay before the first pulse and a limit on the number of periods. All times are counted in cycles of the block clock. Software converts any time unit into cycles before writing.

Writing the enable bit of a channel from clear to set starts that channel. The pin first stays low through the lead-in, and then the channel repeats high/low periods. A repeat limit of zero lets it run without end. A nonzero limit parks the pin low after that many periods, and the channel stays parked until its enable is cleared and set again. New high/low counts written while a channel runs are picked up only at the next period boundary. Clearing the enable, by contrast, drops the pin at once, even in the middle of a period.

Top module: `pwm_bank`

## Requirements
- R1: While reset is asserted and after it is released, every output is low and every register reads back zero.
- R2: Byte address 4*c (addr[5]=0) holds the control word of channel c, and byte address 32+4*c (addr[5]=1) holds its timing word, where c is addr[4:2] and ranges over 0..5. A read returns the last value written, and rdata carries it in the cycle after rd_en. rdata is zero in the cycle after a cycle with no read. Slots 6 and 7, and any address with addr[1:0] nonzero, read as zero and ignore writes.
- R3: The control word holds enable in bit 31, the lead-in count in bits 30:16 and the repeat limit in bits 15:0. The timing word holds the high count in bits 31:16 and the low count in bits 15:0. When enable goes from 0 to 1, the output is low for 1+lead cycles after the write edge. It then repeats periods of high-count cycles high followed by low-count cycles low.
- R4: A repeat limit N>0 ends the run after N periods. The output then stays low until the enable is cleared and set again, and that restart begins again with the lead-in. A limit of 0 never ends the run.
- R5: A high count of 0 keeps the output low, and a low count of 0 with a nonzero high count keeps it high. When both counts are 0, each period is a single low cycle.
- R6: A timing word written while a channel runs is not used until the period in progress ends, and that includes that period's low phase.
- R7: Clearing the enable forces the output low from the cycle after the write edge, even mid-period.
- R8: Writes to one channel change neither the outputs nor the registers of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one word per cycle |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| pwm_out | output | NUM_CH | One waveform output per channel |

## Verification
The bench targets the period boundary. It rewrites the timing in the middle of a high phase and expects the old low phase to run in full before the new counts appear. A design that latched the low count late would cut that period short, and one that reloaded at once would shift the pulse train. It runs repeat limits of one and two and then restarts the channel. A design with an off-by-one period counter would emit an extra or a missing pulse, and one that did not reload the lead-in would start early. It also covers zero high and zero low counts, which a naive counter would underflow into pulses 65536 cycles long, a disable in mid-pulse that a design finishing the period would ignore, and writes to unmapped and misaligned addresses that a loose decoder would alias onto real channels.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
   localparam int REG_W  = 32;
   localparam int ADDR_W = 6;
   localparam int CNT_W  = 16;
   localparam int LEAD_W = 15;
   localparam int RPT_W  = 16;

   // control word: bit 31 run, 30:16 lead-in, 15:0 repeat limit
   typedef struct packed {
      logic              run;
      logic [LEAD_W-1:0] lead;
      logic [RPT_W-1:0]  reps;
   } ctl_word_t;

   // timing word: 31:16 high cycles, 15:0 low cycles
   typedef struct packed {
      logic [CNT_W-1:0] hi;
      logic [CNT_W-1:0] lo;
   } tim_word_t;

   typedef enum logic [2:0] {
      PH_OFF, PH_LEAD, PH_HIGH, PH_LOW, PH_DONE
   } phase_e;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 6
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [REG_W-1:0]        wdata,
   output logic [REG_W-1:0]        rdata,
   output ctl_word_t [NUM_CH-1:0]  ctl_o,
   output tim_word_t [NUM_CH-1:0]  tim_o
);
   localparam int SEL_W = 3;

   logic [SEL_W-1:0] sel;
   logic             is_tim;
   logic             hit;
   logic [REG_W-1:0] rd_mux;

   assign sel    = addr[4:2];
   assign is_tim = addr[5];
   assign hit    = (addr[1:0] == 2'b00) && (int'(sel) < NUM_CH);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
      ctl_word_t ctl_r;
      tim_word_t tim_r;
      logic      wr_sel;

      assign wr_sel = wr_en && hit && (sel == SEL_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctl_r <= '0;
            tim_r <= '0;
         end else if (wr_sel) begin
            if (is_tim) tim_r <= wdata;
            else        ctl_r <= wdata;
         end
      end

      assign ctl_o[c] = ctl_r;
      assign tim_o[c] = tim_r;
   end

   always_comb begin
      rd_mux = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (sel == SEL_W'(c)) rd_mux = is_tim ? tim_o[c] : ctl_o[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             rdata <= '0;
      else if (rd_en && hit)  rdata <= rd_mux;
      else                    rdata <= '0;
   end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
   import pwm_bank_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  ctl_word_t ctl,
   input  tim_word_t tim,
   output logic      wave
);
   phase_e           ph_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] low_q;
   logic [RPT_W-1:0] done_q;
   logic [RPT_W-1:0] lim_q;

   phase_e           st_ph;
   logic [CNT_W-1:0] st_cnt;
   logic             cnt_zero;
   logic             per_end;
   logic [RPT_W-1:0] done_nx;
   logic             last;

   // first phase of a fresh period, taken from the live timing word
   always_comb begin
      if (tim.hi != '0) begin
         st_ph  = PH_HIGH;
         st_cnt = tim.hi - 1'b1;
      end else begin
         st_ph  = PH_LOW;
         st_cnt = (tim.lo != '0) ? tim.lo - 1'b1 : '0;
      end
   end

   assign cnt_zero = (cnt_q == '0);
   assign per_end  = cnt_zero &&
                     ((ph_q == PH_LOW) || ((ph_q == PH_HIGH) && (low_q == '0)));
   assign done_nx  = done_q + 1'b1;
   assign last     = (lim_q != '0) && (done_nx == lim_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_OFF;
         cnt_q  <= '0;
         low_q  <= '0;
         done_q <= '0;
         lim_q  <= '0;
      end else if (!ctl.run) begin
         ph_q <= PH_OFF;
      end else if (per_end) begin
         done_q <= done_nx;
         if (last) begin
            ph_q <= PH_DONE;
         end else begin
            ph_q  <= st_ph;
            cnt_q <= st_cnt;
            low_q <= tim.lo;
         end
      end else begin
         case (ph_q)
            PH_OFF: begin
               lim_q  <= ctl.reps;
               done_q <= '0;
               if (ctl.lead != '0) begin
                  ph_q  <= PH_LEAD;
                  cnt_q <= CNT_W'(ctl.lead) - 1'b1;
               end else begin
                  ph_q  <= st_ph;
                  cnt_q <= st_cnt;
                  low_q <= tim.lo;
               end
            end
            PH_LEAD: begin
               if (cnt_zero) begin
                  ph_q  <= st_ph;
                  cnt_q <= st_cnt;
                  low_q <= tim.lo;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_HIGH: begin
               if (!cnt_zero) begin
                  cnt_q <= cnt_q - 1'b1;
               end else begin
                  ph_q  <= PH_LOW;
                  cnt_q <= low_q - 1'b1;
               end
            end
            PH_LOW:  cnt_q <= cnt_q - 1'b1;
            PH_DONE: ph_q  <= PH_DONE;
            default: ph_q  <= PH_OFF;
         endcase
      end
   end

   assign wave = ctl.run && (ph_q == PH_HIGH);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_nch
      $error("pwm_bank: NUM_CH must be 1..8 to fit the address map");
   end
   if (1 + LEAD_W + RPT_W != REG_W || 2 * CNT_W != REG_W) begin : g_bad_fmt
      $error("pwm_bank: register fields do not fill a word");
   end
   if (LEAD_W > CNT_W) begin : g_bad_lead
      $error("pwm_bank: lead-in wider than the cycle counter");
   end

   ctl_word_t [NUM_CH-1:0] ctl;
   tim_word_t [NUM_CH-1:0] tim;
   logic      [NUM_CH-1:0] ch_en;

   pwm_bank_regs #(.NUM_CH(NUM_CH)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .ctl_o (ctl),
      .tim_o (tim)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign ch_en[c] = ctl[c].run;

      pwm_bank_chan u_chan (
         .clk   (clk),
         .rst_n (rst_n),
         .ctl   (ctl[c]),
         .tim   (tim[c]),
         .wave  (pwm_out[c])
      );
   end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
   parameter int NUM_CH = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [5:0]        addr,
   input logic [31:0]       wdata,
   input logic [31:0]       rdata,
   input logic [NUM_CH-1:0] pwm_out,
   input logic [NUM_CH-1:0] ch_en
);
   // R2: unmapped or misaligned reads return zero
   a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && ((addr[1:0] != 2'b00) || (int'(addr[4:2]) >= NUM_CH)) |=> (rdata == '0));

   // R2: no read request leaves rdata zero next cycle
   a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == '0));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_a
      // R7: clearing enable drops the pin on the next cycle
      a_r7_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
         wr_en && (addr == 6'(4 * c)) && !wdata[31] |=> !pwm_out[c]);

      // R3: the cycle in which a channel becomes enabled is low
      a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_en[c]) |-> !pwm_out[c]);

      // R7: a pin is never high while its enable is clear
      a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[c] |-> !pwm_out[c]);
   end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .pwm_out (pwm_out),
   .ch_en   (ch_en)
);

// File: tb/test_pwm_bank.sv
`timescale 1ns/1ps
module test_pwm_bank;
   localparam int NCH = 6;

   logic           clk   = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic           rd_en = 1'b0;
   logic [5:0]     addr  = '0;
   logic [31:0]    wdata = '0;
   logic [31:0]    rdata;
   logic [NCH-1:0] pwm_out;

   always #2.5 clk = ~clk;

   pwm_bank #(.NUM_CH(NCH)) i_pwm_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
   );

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // scoreboard: one entry per future sample, index 0 = next negedge
   logic [NCH-1:0] q_exp[$];
   logic [NCH-1:0] q_care[$];
   string          q_tag[$];

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   // monitor
   always @(negedge clk) begin : mon
      logic [NCH-1:0] e, m;
      string t;
      if (rst_n && q_exp.size() != 0) begin
         e = q_exp.pop_front();
         m = q_care.pop_front();
         t = q_tag.pop_front();
         if (m != '0) begin
            n_chk++;
            if (((pwm_out ^ e) & m) != '0) begin
               n_fail++;
               $display("FAIL %s cycle %0d pwm_out actual=%b expected=%b mask=%b",
                        t, cyc, pwm_out, e, m);
            end
         end
      end
   end

   // level k samples after the enabling write edge (from the requirements)
   function automatic bit lvl(int k, int nz, int h, int l, int rpt);
      int j, plen;
      if (k < nz) return 1'b0;
      j = k - nz;
      plen = (h + l == 0) ? 1 : h + l;
      if (rpt != 0 && (j / plen) >= rpt) return 1'b0;
      return (j % plen) < h;
   endfunction

   task automatic set_exp(int idx, int ch, bit v, string tag);
      logic [NCH-1:0] te, tm;
      while (q_exp.size() <= idx) begin
         q_exp.push_back('0);
         q_care.push_back('0);
         q_tag.push_back("");
      end
      te = q_exp[idx];  te[ch] = v;    q_exp[idx]  = te;
      tm = q_care[idx]; tm[ch] = 1'b1; q_care[idx] = tm;
      q_tag[idx] = tag;
   endtask

   // driver: push expected samples, first one at queue index 'at'
   task automatic push_wave(int ch, int at, int nz, int h, int l, int rpt, int n, string tag);
      for (int k = 0; k < n; k++) set_exp(at + k, ch, lvl(k, nz, h, l, rpt), tag);
   endtask

   task automatic reg_write(logic [5:0] a, logic [31:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic reg_read_chk(logic [5:0] a, logic [31:0] exp, string tag);
      addr = a; rd_en = 1'b1;
      @(posedge clk); #1;
      rd_en = 1'b0;
      @(negedge clk);
      chk(rdata == exp, tag, rdata, exp);
      @(posedge clk); #1;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic drain();
      while (q_exp.size() != 0) @(posedge clk);
      #1;
   endtask

   function automatic logic [5:0] a_ctl(int ch); return 6'(4 * ch); endfunction
   function automatic logic [5:0] a_tim(int ch); return 6'(32 + 4 * ch); endfunction
   function automatic logic [31:0] mk_ctl(bit en, int lead, int rpt);
      return {en, 15'(lead), 16'(rpt)};
   endfunction
   function automatic logic [31:0] mk_tim(int h, int l);
      return {16'(h), 16'(l)};
   endfunction

   task automatic stop(int ch);
      drain();
      push_wave(ch, 1, 0, 0, 0, 0, 3, "R7");
      reg_write(a_ctl(ch), '0);
      drain();
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk(pwm_out == '0, "R1 outputs in reset", 32'(pwm_out), 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      wait_cyc(2);
      chk(pwm_out == '0, "R1 outputs after reset", 32'(pwm_out), 0);
      reg_read_chk(a_ctl(0), 0, "R1 ctl0");
      reg_read_chk(a_tim(5), 0, "R1 tim5");

      // R2: readback, unmapped and misaligned
      reg_write(a_ctl(3), 32'h0ABC_1234);
      reg_write(a_tim(4), 32'hDEAD_BEEF);
      reg_write(6'h18, 32'h5555_AAAA);
      reg_write(6'h31, 32'h1111_2222);
      reg_read_chk(a_ctl(3), 32'h0ABC_1234, "R2 ctl3 readback");
      reg_read_chk(a_tim(4), 32'hDEAD_BEEF, "R2 tim4 readback (misaligned write dropped)");
      reg_read_chk(6'h18, 0, "R2 unmapped slot reads zero");
      reg_read_chk(6'h31, 0, "R2 misaligned reads zero");
      reg_read_chk(a_ctl(4), 0, "R8 ctl4 untouched by neighbours");
      chk(pwm_out == '0, "R2 no output from disabled writes", 32'(pwm_out), 0);
      reg_write(a_ctl(3), '0);

      // R3: lead-in 4, high 3, low 2, endless; R8: other pins stay low
      reg_write(a_tim(0), mk_tim(3, 2));
      push_wave(0, 1, 5, 3, 2, 0, 40, "R3");
      for (int c = 1; c < NCH; c++) push_wave(c, 1, 1, 0, 0, 0, 40, "R8");
      reg_write(a_ctl(0), mk_ctl(1, 4, 0));
      drain();
      stop(0);

      // R4: limit 2 with lead-in 2, then restart
      reg_write(a_tim(2), mk_tim(3, 2));
      push_wave(2, 1, 3, 3, 2, 2, 30, "R4");
      reg_write(a_ctl(2), mk_ctl(1, 2, 2));
      drain();
      push_wave(2, 1, 0, 0, 0, 0, 1, "R4");
      push_wave(2, 2, 3, 3, 2, 2, 20, "R4");
      reg_write(a_ctl(2), '0);
      reg_write(a_ctl(2), mk_ctl(1, 2, 2));
      drain();
      stop(2);

      // R4: limit 1, no lead-in
      reg_write(a_tim(4), mk_tim(2, 1));
      push_wave(4, 1, 1, 2, 1, 1, 12, "R4");
      reg_write(a_ctl(4), mk_ctl(1, 0, 1));
      drain();
      stop(4);

      // R5: zero-count cases on three channels at once
      reg_write(a_tim(1), mk_tim(0, 5));
      reg_write(a_tim(3), mk_tim(5, 0));
      reg_write(a_tim(5), mk_tim(0, 0));
      push_wave(1, 1, 1, 0, 5, 0, 20, "R5");
      push_wave(3, 2, 1, 5, 0, 0, 20, "R5");
      push_wave(5, 3, 1, 0, 0, 0, 20, "R5");
      reg_write(a_ctl(1), mk_ctl(1, 0, 0));
      reg_write(a_ctl(3), mk_ctl(1, 0, 0));
      reg_write(a_ctl(5), mk_ctl(1, 0, 0));
      drain();
      stop(1);
      stop(3);
      stop(5);

      // R6: timing rewritten during the first high phase
      reg_write(a_tim(5), mk_tim(4, 4));
      push_wave(5, 1, 1, 4, 4, 0, 9, "R6");
      reg_write(a_ctl(5), mk_ctl(1, 0, 0));
      wait_cyc(2);
      reg_write(a_tim(5), mk_tim(2, 3));
      push_wave(5, 6, 0, 2, 3, 0, 20, "R6");
      drain();
      stop(5);

      // R7: disable in the middle of a long high phase
      reg_write(a_tim(0), mk_tim(10, 10));
      push_wave(0, 1, 1, 10, 10, 0, 3, "R7");
      reg_write(a_ctl(0), mk_ctl(1, 0, 0));
      wait_cyc(2);
      push_wave(0, 1, 0, 0, 0, 0, 10, "R7");
      reg_write(a_ctl(0), '0);
      drain();

      // R8: registers of other channels kept their values
      reg_read_chk(a_tim(4), mk_tim(2, 1), "R8 tim4 kept");
      reg_read_chk(a_tim(0), mk_tim(10, 10), "R8 tim0 kept");
      chk(pwm_out == '0, "R7 all low at end", 32'(pwm_out), 0);

      finish_run();
   end
endmodule